// File: doc/BRIEF.md
# Bridge Excitation Phase Generator

This block drives the pair of control lines that set the polarity of the excitation voltage across an external bridge while chopped conversions run. One line is high while the excitation is applied the normal way round. Its complement is high while the excitation is reversed. A conversion sequencer sends a one-cycle toggle request whenever it wants the polarity flipped. The block then lowers the active line, holds both lines low for exactly one master-clock cycle, and raises the other line.

Alternating excitation only runs when both the AC-excitation enable and the chop enable are set. If either enable is clear, the block parks the normal line high and the reverse line low. A phase flag follows the reversed state so that a downstream chop demodulator knows when to negate results. A synchronous reset or a sync pulse puts the block back into normal polarity.

Top module: `excite_phase_gen`

## Requirements
- R1: After a clock edge with `rst` high, `drv_pos` is 1, `drv_neg` is 0 and `phase_rev` is 0.
- R2: While `ac_en` is 0 or `chop_en` is 0, the outputs stay at `drv_pos`=1, `drv_neg`=0, `phase_rev`=0, and `toggle_req` pulses have no effect.
- R3: With both enables set and normal polarity active, a `toggle_req` pulse sampled at edge k makes both outputs low after edge k. After edge k+1, `drv_neg` is 1 and `drv_pos` is 0.
- R4: With both enables set and reversed polarity active, a `toggle_req` pulse sampled at edge k makes both outputs low after edge k. After edge k+1, `drv_pos` is 1 and `drv_neg` is 0.
- R5: `drv_pos` and `drv_neg` are never 1 together. When both enables stay set, every change of the active line passes through exactly one cycle with both lines low.
- R6: A `toggle_req` sampled during the dead-time cycle is held. The new phase lasts one cycle, and the next dead time then begins.
- R7: `phase_rev` (0 = normal, 1 = reversed) changes only on the edge where the newly active line rises. During a dead-time cycle it keeps its old value.
- R8: A clock edge with `sync_req` high returns the block to normal polarity (`drv_pos`=1, `drv_neg`=0, `phase_rev`=0) and discards any held request.
- R9: If an enable drops while a transition is in progress, the outputs take the static levels at the next clock edge.
- R10: Without a toggle request, the current phase is kept indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_req | input | 1 | Synchronous return to normal phase, active high |
| ac_en | input | 1 | AC-excitation enable |
| chop_en | input | 1 | Chop mode enable |
| toggle_req | input | 1 | One-cycle request to reverse the excitation |
| drv_pos | output | 1 | Normal-polarity drive, high = normal excitation |
| drv_neg | output | 1 | Reverse-polarity drive, complement of `drv_pos` outside dead time |
| phase_rev | output | 1 | Active phase: 0 normal, 1 reversed |

## Verification
All three outputs are registered. A request or mode change sampled at one edge is visible right after that edge. The dead time appears one edge after the request, and the new line rises one edge after that. A held request from the dead time opens the next dead time two edges after it was sampled. The bench changes inputs on the falling clock edge and keeps a behavioural model that advances on each rising edge. It compares the model with all three outputs 2 ns after every rising edge. Directed checks sample at the falling edge, after counting the edges listed above.

// File: rtl/exc_phase_pkg.sv
package exc_phase_pkg;

  typedef enum logic [1:0] {
    PH_NORM     = 2'd0,
    PH_GAP_REV  = 2'd1,
    PH_REV      = 2'd2,
    PH_GAP_NORM = 2'd3
  } ph_state_t;

  // Next step of the phase sequence when enabled; go asks for a reversal.
  function automatic ph_state_t ph_advance(ph_state_t cur, logic go);
    ph_state_t nxt;
    case (cur)
      PH_NORM:     nxt = go ? PH_GAP_REV : PH_NORM;
      PH_GAP_REV:  nxt = PH_REV;
      PH_REV:      nxt = go ? PH_GAP_NORM : PH_REV;
      default:     nxt = PH_NORM;
    endcase
    return nxt;
  endfunction

  function automatic logic ph_is_gap(ph_state_t s);
    return (s == PH_GAP_REV) || (s == PH_GAP_NORM);
  endfunction

  // Drive levels for a state: {pos, neg, phase}
  function automatic logic [2:0] ph_levels(ph_state_t s);
    logic [2:0] lv;
    case (s)
      PH_NORM: lv = 3'b100;
      PH_REV:  lv = 3'b011;
      PH_GAP_REV: lv = 3'b000;
      default: lv = 3'b001;
    endcase
    return lv;
  endfunction

endpackage

// File: rtl/exc_req_hold.sv
module exc_req_hold (
  input  logic clk,
  input  logic clr,
  input  logic toggle_req,
  input  logic in_gap,
  output logic go
);
  logic pending;

  always_ff @(posedge clk) begin
    if (clr)         pending <= 1'b0;
    else if (in_gap) pending <= pending | toggle_req;
    else             pending <= 1'b0;
  end

  assign go = !in_gap && (toggle_req || pending);

endmodule

// File: rtl/exc_phase_fsm.sv
module exc_phase_fsm
  import exc_phase_pkg::*;
(
  input  logic      clk,
  input  logic      clr,
  input  logic      go,
  output ph_state_t state_q,
  output ph_state_t state_d,
  output logic      in_gap
);

  always_comb begin
    if (clr) state_d = PH_NORM;
    else     state_d = ph_advance(state_q, go);
  end

  always_ff @(posedge clk) state_q <= state_d;

  assign in_gap = ph_is_gap(state_q);

endmodule

// File: rtl/exc_drive_out.sv
module exc_drive_out
  import exc_phase_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  ph_state_t state_d,
  output logic      drv_pos,
  output logic      drv_neg,
  output logic      phase_rev
);
  logic [2:0] lv_d;

  assign lv_d = ph_levels(state_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_pos   <= 1'b1;
      drv_neg   <= 1'b0;
      phase_rev <= 1'b0;
    end else begin
      drv_pos   <= lv_d[2];
      drv_neg   <= lv_d[1];
      phase_rev <= lv_d[0];
    end
  end

  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (rst)
    !(drv_pos && drv_neg)); // R5
  AST_PHASE_REV_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(phase_rev) |-> $rose(drv_neg)); // R7
  AST_PHASE_REV_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(phase_rev) |-> $rose(drv_pos)); // R7

endmodule

// File: rtl/excite_phase_gen.sv
module excite_phase_gen
  import exc_phase_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sync_req,
  input  logic ac_en,
  input  logic chop_en,
  input  logic toggle_req,
  output logic drv_pos,
  output logic drv_neg,
  output logic phase_rev
);
  logic      en_both;
  logic      clr;
  logic      go;
  logic      in_gap;
  ph_state_t state_q;
  ph_state_t state_d;

  assign en_both = ac_en && chop_en;
  assign clr     = rst || sync_req || !en_both;

  exc_req_hold u_hold (
    .clk        (clk),
    .clr        (clr),
    .toggle_req (toggle_req),
    .in_gap     (in_gap),
    .go         (go)
  );

  exc_phase_fsm u_fsm (
    .clk     (clk),
    .clr     (clr),
    .go      (go),
    .state_q (state_q),
    .state_d (state_d),
    .in_gap  (in_gap)
  );

  exc_drive_out u_drv (
    .clk       (clk),
    .rst       (rst),
    .state_d   (state_d),
    .drv_pos   (drv_pos),
    .drv_neg   (drv_neg),
    .phase_rev (phase_rev)
  );

  AST_STATIC_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !en_both |=> (drv_pos && !drv_neg && !phase_rev)); // R2
  AST_GAP_ON_GO: assert property (@(posedge clk) disable iff (rst)
    (go && en_both && !sync_req) |=> (!drv_pos && !drv_neg)); // R3
  AST_GAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (!drv_pos && !drv_neg && en_both && !sync_req) |=> (drv_pos ^ drv_neg)); // R5
  AST_NEG_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_neg) |-> $past(!drv_pos && !drv_neg)); // R5
  AST_POS_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
    ($rose(drv_pos) && $past(en_both && !sync_req)) |-> $past(!drv_neg)); // R5
  AST_SYNC_NORMAL: assert property (@(posedge clk) disable iff (rst)
    sync_req |=> (drv_pos && !drv_neg && !phase_rev)); // R8

endmodule

// File: tb/excite_phase_gen_test.sv
`timescale 1ns/1ps
module excite_phase_gen_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_req = 1'b0;
  logic ac_en = 1'b0;
  logic chop_en = 1'b0;
  logic toggle_req = 1'b0;
  logic drv_pos, drv_neg, phase_rev;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // model: 0 normal, 1 dead toward reversed, 2 reversed, 3 dead toward normal
  int  m_mode = 0;
  bit  m_held = 0;

  always #5 clk = ~clk;

  excite_phase_gen uut (
    .clk(clk), .rst(rst), .sync_req(sync_req), .ac_en(ac_en),
    .chop_en(chop_en), .toggle_req(toggle_req),
    .drv_pos(drv_pos), .drv_neg(drv_neg), .phase_rev(phase_rev)
  );

  always @(posedge clk) begin
    if (rst || sync_req || !(ac_en && chop_en)) begin
      m_mode = 0;
      m_held = 0;
    end else if (m_mode == 1 || m_mode == 3) begin
      m_held = m_held || toggle_req;
      m_mode = (m_mode + 1) % 4;
    end else if (toggle_req || m_held) begin
      m_held = 0;
      m_mode = m_mode + 1;
    end
  end

  always @(posedge clk) begin
    #2;
    if (!finished) begin
      compared++;
      if (drv_pos !== (m_mode == 0) || drv_neg !== (m_mode == 2) ||
          phase_rev !== (m_mode == 2 || m_mode == 3)) begin
        mismatched++;
        $display("FAIL cycle model R3 R4 R5 R6 R7: got pos=%b neg=%b ph=%b expected mode %0d",
                 drv_pos, drv_neg, phase_rev, m_mode);
      end
    end
  end

  task automatic chk(string req, logic [2:0] got, logic [2:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got {pos,neg,ph}=%b expected %b", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [2:0] outs();
    return {drv_pos, drv_neg, phase_rev};
  endfunction

  task automatic finish_run();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    tick(); tick(); tick();
    chk("R1 reset", outs(), 3'b100);
    rst = 0;
    ac_en = 1; chop_en = 1;
    tick(); tick(); tick();
    chk("R10 idle normal", outs(), 3'b100);

    // R3 normal -> reversed
    toggle_req = 1; tick(); toggle_req = 0;
    chk("R3 dead after request", outs(), 3'b000);
    tick();
    chk("R3 reversed after dead", outs(), 3'b011);
    tick(); tick(); tick(); tick();
    chk("R10 reversed held", outs(), 3'b011);

    // R4 reversed -> normal; R7 phase held in dead time
    toggle_req = 1; tick(); toggle_req = 0;
    chk("R7 phase kept in dead", outs(), 3'b001);
    tick();
    chk("R4 normal after dead", outs(), 3'b100);

    // R6 request during dead time
    toggle_req = 1; tick();
    chk("R6 first dead", outs(), 3'b000);
    tick(); toggle_req = 0;
    chk("R6 reversed one cycle", outs(), 3'b011);
    tick();
    chk("R6 held request dead", outs(), 3'b001);
    tick();
    chk("R6 back to normal", outs(), 3'b100);

    // R2 disabled: ac off, then chop off
    ac_en = 0;
    for (int i = 0; i < 4; i++) begin toggle_req = 1; tick(); end
    toggle_req = 0; tick();
    chk("R2 ac off static", outs(), 3'b100);
    ac_en = 1; chop_en = 0;
    for (int i = 0; i < 4; i++) begin toggle_req = 1; tick(); end
    toggle_req = 0; tick();
    chk("R2 chop off static", outs(), 3'b100);
    chop_en = 1; tick();

    // R9 disable mid transition
    toggle_req = 1; tick(); toggle_req = 0;
    chk("R9 in dead", outs(), 3'b000);
    chop_en = 0; tick();
    chk("R9 static from dead", outs(), 3'b100);
    chop_en = 1;
    toggle_req = 1; tick(); toggle_req = 0; tick();
    chk("R9 reached reversed", outs(), 3'b011);
    ac_en = 0; tick();
    chk("R9 static from reversed", outs(), 3'b100);
    ac_en = 1; tick();

    // R8 sync
    toggle_req = 1; tick(); toggle_req = 0; tick();
    chk("R8 reversed before sync", outs(), 3'b011);
    sync_req = 1; tick();
    chk("R8 sync to normal", outs(), 3'b100);
    toggle_req = 1; tick(); toggle_req = 0; tick();
    chk("R8 toggle ignored under sync", outs(), 3'b100);
    sync_req = 0; tick();
    // R8 held request discarded by sync
    toggle_req = 1; tick(); sync_req = 1; tick(); toggle_req = 0; sync_req = 0; tick(); tick();
    chk("R8 held request dropped", outs(), 3'b100);

    // random traffic compared against the model each cycle
    for (int i = 0; i < 3000; i++) begin
      toggle_req = ($urandom_range(0, 3) == 0);
      sync_req   = ($urandom_range(0, 99) == 0);
      ac_en      = ($urandom_range(0, 39) != 0);
      chop_en    = ($urandom_range(0, 39) != 0);
      tick();
    end
    toggle_req = 0; sync_req = 0;
    rst = 1; tick();
    chk("R1 reset after traffic", outs(), 3'b100);
    finish_run();
  end

endmodule